// File: doc/BRIEF.md
# Codec Identity and Daisy-Chain Selector

This block sits inside one audio codec that may share a serial link with up to three others. Two active-low strap pins set the codec's identity. The block inverts them into a two-bit identity value. Identity 0 marks the primary codec, and the other three values mark secondary codecs. Software reads the identity from bits 15:14 of a read-only register.

A two-bit chain field lives in a writable register. Cold reset loads it with the identity, so pass-through starts off. While the field matches the identity, the serial data output carries the codec's own data. Once software writes a value that differs from the identity, the codec drops its own data and forwards its chain-in input to the output. This lets the codecs on a link be daisy-chained. Writing the identity back into the field turns pass-through off again.

The same register port also holds one control bit that drives the external amplifier's power-down pin. Register access uses an address, write data, a write strobe and a combinational read-data bus.

Top module: `codec_link_ident`

## Requirements
- R1: The identity equals the bitwise inverse of the two pins: a pin at 0 gives a 1 bit, and a pin at 1 gives a 0 bit. A read of address 28h returns the identity in bits 15:14 and zeros in bits 13:0.
- R2: A write to address 28h changes no readable value and no output.
- R3: The clock edge that samples rst_n low does three things. It loads the chain field (address 74h, bits 1:0) with the identity, clears the pass-through state, and clears the amplifier bit. After it, sdata_out follows own_sdata.
- R4: Writing a value to 74h bits 1:0 that differs from the identity has a two-step effect. The field reads back the new value after the write edge. sdata_out follows chain_in from the following edge on.
- R5: Writing the identity back into 74h bits 1:0 returns sdata_out to own_sdata from the edge after the write edge.
- R6: Bit 15 written to address 26h drives amp_pd after the write edge and reads back at 26h bit 15. Bits 14:0 of 26h read 0, and amp_pd is 0 after reset.
- R7: primary_mode is 1 exactly when the identity is 0, that is, when both pins are 1.
- R8: Bits 15:2 of address 74h read 0. Any address other than 26h, 28h or 74h reads 0.
- R9: With reg_we low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Cold reset, active low, sampled on clk |
| id_pin_n | input | 2 | Active-low identity strap pins |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| own_sdata | input | 1 | The codec's own serial data |
| chain_in | input | 1 | Serial data from the next codec in the chain |
| sdata_out | output | 1 | Selected serial data output |
| amp_pd | output | 1 | External amplifier power-down control |
| primary_mode | output | 1 | High when the identity selects primary mode |

## Verification
Read data and primary_mode are combinational. They are due in the same cycle as the address or pins that produce them. A register write shows on reg_rdata and amp_pd one edge after the strobe. A change of data source reaches sdata_out one edge later still, because the compare result is registered.

The bench drives inputs on the falling edge. Its reference model steps on each rising edge in that same order, computing the compare from the old field value before applying the write. Every output is then compared on the following falling edge, so the one-cycle lag of the source switch is checked on every cycle.

// File: rtl/codec_id_pkg.sv
package codec_id_pkg;
  localparam int ID_W = 2;
  localparam logic [6:0] ADDR_PWR   = 7'h26;
  localparam logic [6:0] ADDR_XID   = 7'h28;
  localparam logic [6:0] ADDR_CHAIN = 7'h74;
  localparam int XID_ID_LSB  = 14;
  localparam int PWR_AMP_BIT = 15;

  typedef logic [ID_W-1:0] cid_t;

  // active-low straps become active-high identity bits
  function automatic cid_t pins_to_id(cid_t pins);
    return ~pins;
  endfunction

  // pass-through is wanted whenever the field disagrees with the identity
  function automatic logic chain_differs(cid_t field, cid_t id);
    return field != id;
  endfunction
endpackage

// File: rtl/cid_pin_decode.sv
module cid_pin_decode
  import codec_id_pkg::*;
(
  input  cid_t id_pin_n,
  output cid_t id,
  output logic primary
);
  assign id      = pins_to_id(id_pin_n);
  assign primary = (id == '0);
endmodule

// File: rtl/cid_regs.sv
module cid_regs
  import codec_id_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cid_t          id,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output cid_t          chain_field,
  output logic          amp_q
);
  localparam int CHW = ID_W;

  logic wr_chain, wr_pwr;
  logic unused_wbits;

  assign wr_chain = we && (addr == AW'(ADDR_CHAIN));
  assign wr_pwr   = we && (addr == AW'(ADDR_PWR));
  assign unused_wbits = ^{wdata[DW-2:CHW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_field <= id;
      amp_q       <= 1'b0;
    end else begin
      if (wr_chain) chain_field <= wdata[CHW-1:0];
      if (wr_pwr)   amp_q       <= wdata[PWR_AMP_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_XID)) begin
      rdata[XID_ID_LSB +: ID_W] = id;
    end else if (addr == AW'(ADDR_CHAIN)) begin
      rdata[CHW-1:0] = chain_field;
    end else if (addr == AW'(ADDR_PWR)) begin
      rdata[PWR_AMP_BIT] = amp_q;
    end
  end
endmodule

// File: rtl/cid_chain_mux.sv
module cid_chain_mux
  import codec_id_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cid_t chain_field,
  input  cid_t id,
  input  logic own_sdata,
  input  logic chain_in,
  output logic pass_q,
  output logic sdata_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= chain_differs(chain_field, id);
  end

  assign sdata_out = pass_q ? chain_in : own_sdata;
endmodule

// File: rtl/codec_link_ident.sv
module codec_link_ident
  import codec_id_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    id_pin_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  output logic [DW-1:0] reg_rdata,
  input  logic          own_sdata,
  input  logic          chain_in,
  output logic          sdata_out,
  output logic          amp_pd,
  output logic          primary_mode
);
  cid_t id;
  cid_t chain_field;
  logic chain_pass;

  cid_pin_decode u_dec (
    .id_pin_n (id_pin_n),
    .id       (id),
    .primary  (primary_mode)
  );

  cid_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .id          (id),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .we          (reg_we),
    .rdata       (reg_rdata),
    .chain_field (chain_field),
    .amp_q       (amp_pd)
  );

  cid_chain_mux u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .chain_field (chain_field),
    .id          (id),
    .own_sdata   (own_sdata),
    .chain_in    (chain_in),
    .pass_q      (chain_pass),
    .sdata_out   (sdata_out)
  );
endmodule

// File: rtl/cid_checker.sv
module cid_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  id_pin_n,
  input logic [6:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_we,
  input logic [15:0] reg_rdata,
  input logic        amp_pd,
  input logic        primary_mode,
  input logic [1:0]  chain_field,
  input logic        chain_pass
);
  logic unused_chk;
  assign unused_chk = ^{reg_wdata[14:2]};

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 7'h28) |-> (reg_rdata == {~id_pin_n, 14'h0})); // R1
  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chain_field == ~id_pin_n && !chain_pass && !amp_pd)); // R3
  AST_PASS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_field != ~id_pin_n) |=> chain_pass); // R4
  AST_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_field == ~id_pin_n) |=> !chain_pass); // R5
  AST_CHAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 7'h74) |=> (chain_field == $past(reg_wdata[1:0]))); // R4
  AST_AMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 7'h26) |=> (amp_pd == $past(reg_wdata[15]))); // R6
  AST_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    primary_mode == (id_pin_n == 2'b11)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 7'h26 && reg_addr != 7'h28 && reg_addr != 7'h74) |-> (reg_rdata == 16'h0)); // R8
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(chain_field) && $stable(amp_pd))); // R9
endmodule

bind codec_link_ident cid_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .id_pin_n     (id_pin_n),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_we       (reg_we),
  .reg_rdata    (reg_rdata),
  .amp_pd       (amp_pd),
  .primary_mode (primary_mode),
  .chain_field  (chain_field),
  .chain_pass   (chain_pass)
);

// File: tb/codec_link_ident_bench.sv
`timescale 1ns/1ps
module codec_link_ident_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  id_pin_n = 2'b11;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic        own_sdata = 1'b0;
  logic        chain_in = 1'b0;
  logic        sdata_out;
  logic        amp_pd;
  logic        primary_mode;

  int checks = 0;
  int errors = 0;
  string cur_req = "R3";
  bit done = 1'b0;

  // reference model state
  int m_field = 0;
  int m_pass  = 0;
  int m_amp   = 0;

  always #2 clk = ~clk;

  codec_link_ident u_codec_link_ident (
    .clk(clk), .rst_n(rst_n), .id_pin_n(id_pin_n), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .own_sdata(own_sdata), .chain_in(chain_in), .sdata_out(sdata_out),
    .amp_pd(amp_pd), .primary_mode(primary_mode)
  );

  function automatic int ident();
    return 3 - int'(id_pin_n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_field = ident();
      m_pass  = 0;
      m_amp   = 0;
    end else begin
      m_pass = (m_field != ident()) ? 1 : 0;
      if (reg_we && reg_addr == 7'h74) m_field = int'(reg_wdata) % 4;
      if (reg_we && reg_addr == 7'h26) m_amp = (int'(reg_wdata) >= 32768) ? 1 : 0;
    end
  end

  function automatic int model_read();
    case (reg_addr)
      7'h28:   return ident() * 16384;
      7'h74:   return m_field;
      7'h26:   return m_amp * 32768;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int er, es;
    er = model_read();
    es = (m_pass != 0) ? int'(chain_in) : int'(own_sdata);
    check(int'(reg_rdata) == er, cur_req, "reg_rdata", int'(reg_rdata), er);
    check(int'(sdata_out) == es, cur_req, "sdata_out", int'(sdata_out), es);
    check(int'(amp_pd) == m_amp, (cur_req == "R6") ? "R6" : cur_req, "amp_pd", int'(amp_pd), m_amp);
    check(primary_mode == (ident() == 0), "R7", "primary_mode", int'(primary_mode), int'(ident() == 0));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n || checks > 0) compare();
    own_sdata = ~own_sdata;
    if ((checks % 3) == 0) chain_in = ~chain_in;
  endtask

  task automatic access(bit we, logic [6:0] a, logic [15:0] d, int n);
    reg_we = we; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
    for (int i = 1; i < n; i++) tick();
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      int id;
      @(negedge clk);
      cur_req = "R3";
      rst_n = 1'b0;
      id_pin_n = 2'(p);
      id = 3 - p;
      access(1'b0, 7'h74, 16'h0, 3);
      rst_n = 1'b1;
      access(1'b0, 7'h74, 16'h0, 4);
      cur_req = "R1";
      access(1'b0, 7'h28, 16'h0, 2);
      cur_req = "R2";
      access(1'b1, 7'h28, 16'hFFFF, 2);
      access(1'b0, 7'h74, 16'h0, 2);
      access(1'b0, 7'h26, 16'h0, 2);
      cur_req = "R8";
      access(1'b0, 7'h10, 16'h0, 1);
      access(1'b0, 7'h7E, 16'h0, 1);
      access(1'b0, 7'h27, 16'h0, 1);
      cur_req = "R4";
      access(1'b1, 7'h74, 16'hFFFC | 16'((id ^ 1) % 4), 6);
      access(1'b1, 7'h74, 16'h5558 | 16'((id ^ 2) % 4), 6);
      cur_req = "R5";
      access(1'b1, 7'h74, 16'(id), 6);
      cur_req = "R6";
      access(1'b1, 7'h26, 16'h8000, 3);
      access(1'b1, 7'h26, 16'h7FFF, 3);
      access(1'b1, 7'h26, 16'hFFFF, 3);
      cur_req = "R9";
      access(1'b0, 7'h74, 16'h0003 ^ 16'(id), 3);
      access(1'b0, 7'h26, 16'h0000, 3);
      access(1'b0, 7'h74, 16'h0000, 2);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule